// File: doc/BRIEF.md
# Sequence Conversion-Complete Flag Register

This block holds one completion flag for each slot of a conversion sequence run by a sequencing analog-to-digital converter. When the converter finishes the conversion for slot x and its result is in result register x, it raises a done strobe together with the slot index, and flag x goes high. Software reads the flag vector through the status register and then collects results. The reads themselves clear the flags, and there are two ways this can work.

In paired mode (`fast_clr` = 0), a result read clears its flag only if a status read has already shown that flag as set. In fast mode (`fast_clr` = 1), the result read alone clears the flag. A write to the sequence-start control register clears every flag at once. All clearing is allowed only while the converter is powered up. When a set and a clear of the same flag land in the same cycle, the outcome depends on the kind of clear.

The block is written for a parameterised number of sequence slots, with eight by default. Every flag change appears on `flags_o` one clock after the strobe that causes it.

Top module: `cvt_done_flags`

## Requirements
- R1: While reset is active, and in the cycles after it is released, all flags read 0.
- R2: A done strobe with slot index p (a binary number from 0 to NUM_POS-1) sets flag p on the next clock. No flag rises without a done strobe.
- R3: While `pwr_en` is 0, neither sequence-start writes nor result reads clear any flag.
- R4: With `pwr_en` = 1, a sequence-start write clears all flags on the next clock.
- R5: In paired mode (`fast_clr` = 0), a status read while flag x is set, followed by a later read of result x, clears flag x.
- R6: In paired mode, a read of result x with no earlier status read showing flag x set leaves flag x set.
- R7: In fast mode (`fast_clr` = 1), a read of result x clears flag x and leaves all other flags unchanged.
- R8: A sequence-start clear and a set in the same cycle leave all flags cleared.
- R9: A read-based clear and a set of the same flag in the same cycle leave that flag set.
- R10: The status-read mark for flag x is used up by the clear it enables. Once flag x is set again, a further result read needs a new status read before it clears the flag.
- R11: A sequence-start write discards every pending status-read mark.
- R12: A status read marks only the flags that were set before that cycle. A flag that is set in the same cycle as the status read is not marked.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| done_vld | input | 1 | Conversion done strobe |
| done_pos | input | IDX_W | Sequence slot of the finished conversion |
| pwr_en | input | 1 | Converter powered; all clearing is allowed only when this is 1 |
| fast_clr | input | 1 | 1 = a result read alone clears its flag; 0 = paired status/result clear |
| seq_start_wr | input | 1 | Strobe for a write to the sequence-start control register |
| stat_rd | input | 1 | Strobe for a read of this status register |
| res_rd | input | 1 | Strobe for a read of a result register |
| res_idx | input | IDX_W | Index of the result register being read |
| flags_o | output | NUM_POS | Flag vector, bit x for sequence slot x |

## Verification
The assertions rely on slot and result indices that are below NUM_POS whenever their strobe is high. They also rely on the mode and power inputs being sampled in the same cycle as the strobes they qualify. The bench changes each input only at a falling edge. It holds every strobe for exactly one cycle and draws indices from 0 to 7 only. Mode and power changes come between sequences of strobes. The bench also drives the collision cases on purpose: a set with a sequence start, a set with a result read, and a set with a status read.

// File: rtl/cdf_pkg.sv
package cdf_pkg;
  typedef enum logic {
    CLR_PAIRED = 1'b0,
    CLR_FAST   = 1'b1
  } clr_mode_e;

  localparam int unsigned DEF_POSITIONS = 8;
endpackage

// File: rtl/cdf_rst_sync.sv
module cdf_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sync_n = stage_q[1];
endmodule

// File: rtl/cdf_pos_decode.sv
module cdf_pos_decode #(
  parameter int unsigned N  = 8,
  parameter int unsigned IW = 3
) (
  input  logic          vld,
  input  logic [IW-1:0] idx,
  output logic [N-1:0]  hot
);
  for (genvar g = 0; g < N; g++) begin : g_slot
    assign hot[g] = vld && (idx == IW'(g));
  end
endmodule

// File: rtl/cdf_access_clear.sv
module cdf_access_clear
  import cdf_pkg::*;
#(
  parameter int unsigned N = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pwr_en,
  input  clr_mode_e  mode,
  input  logic       seq_clr,
  input  logic       stat_rd,
  input  logic [N-1:0] rd_hot,
  input  logic [N-1:0] flags_q,
  output logic [N-1:0] acc_clr,
  output logic [N-1:0] seen_q
);
  logic [N-1:0] seen_d;
  logic         seen_en;

  // Clear request that comes from register access
  always_comb begin
    acc_clr = '0;
    if (pwr_en) begin
      if (mode == CLR_FAST) acc_clr = rd_hot;
      else                  acc_clr = rd_hot & seen_q;
    end
  end

  // Status-read marks: captured from pre-edge flags, consumed by access clears
  always_comb begin
    seen_en = seq_clr | stat_rd | (|acc_clr);
    if (seq_clr) seen_d = '0;
    else         seen_d = (seen_q | (stat_rd ? flags_q : '0)) & ~acc_clr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       seen_q <= '0;
    else if (seen_en) seen_q <= seen_d;
  end
endmodule

// File: rtl/cdf_flag_bank.sv
module cdf_flag_bank #(
  parameter int unsigned N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_hot,
  input  logic [N-1:0] acc_clr,
  input  logic         seq_clr,
  output logic [N-1:0] flags_q
);
  logic [N-1:0] flags_d;
  logic         flags_en;

  // Priority: sequence clear > set > access clear
  always_comb begin
    flags_en = seq_clr | (|set_hot) | (|acc_clr);
    if (seq_clr) flags_d = '0;
    else         flags_d = (flags_q & ~acc_clr) | set_hot;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        flags_q <= '0;
    else if (flags_en) flags_q <= flags_d;
  end
endmodule

// File: rtl/cvt_done_flags.sv
module cvt_done_flags
  import cdf_pkg::*;
#(
  parameter int unsigned NUM_POS = DEF_POSITIONS,
  localparam int unsigned IDX_W  = (NUM_POS > 1) ? $clog2(NUM_POS) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               done_vld,
  input  logic [IDX_W-1:0]   done_pos,
  input  logic               pwr_en,
  input  logic               fast_clr,
  input  logic               seq_start_wr,
  input  logic               stat_rd,
  input  logic               res_rd,
  input  logic [IDX_W-1:0]   res_idx,
  output logic [NUM_POS-1:0] flags_o
);
  logic               rst_sync_n;
  logic [NUM_POS-1:0] set_hot;
  logic [NUM_POS-1:0] rd_hot;
  logic [NUM_POS-1:0] acc_clr;
  logic [NUM_POS-1:0] seen_q;
  logic [NUM_POS-1:0] flags_q;
  logic               seq_clr;
  clr_mode_e          mode;

  assign mode    = clr_mode_e'(fast_clr);
  assign seq_clr = pwr_en & seq_start_wr;

  cdf_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  cdf_pos_decode #(.N(NUM_POS), .IW(IDX_W)) u_set_dec (
    .vld (done_vld),
    .idx (done_pos),
    .hot (set_hot)
  );

  cdf_pos_decode #(.N(NUM_POS), .IW(IDX_W)) u_rd_dec (
    .vld (res_rd),
    .idx (res_idx),
    .hot (rd_hot)
  );

  cdf_access_clear #(.N(NUM_POS)) u_acc (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .pwr_en  (pwr_en),
    .mode    (mode),
    .seq_clr (seq_clr),
    .stat_rd (stat_rd),
    .rd_hot  (rd_hot),
    .flags_q (flags_q),
    .acc_clr (acc_clr),
    .seen_q  (seen_q)
  );

  cdf_flag_bank #(.N(NUM_POS)) u_bank (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .set_hot (set_hot),
    .acc_clr (acc_clr),
    .seq_clr (seq_clr),
    .flags_q (flags_q)
  );

  assign flags_o = flags_q;
endmodule

// File: rtl/cdf_chk.sv
module cdf_chk #(
  parameter int unsigned NUM_POS = 8,
  parameter int unsigned IDX_W   = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic               done_vld,
  input logic [IDX_W-1:0]   done_pos,
  input logic               pwr_en,
  input logic               fast_clr,
  input logic               seq_start_wr,
  input logic               stat_rd,
  input logic               res_rd,
  input logic [IDX_W-1:0]   res_idx,
  input logic [NUM_POS-1:0] seen_q,
  input logic [NUM_POS-1:0] flags_o
);
  AST_SET_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    done_vld && !(pwr_en && seq_start_wr) |=> flags_o[$past(done_pos)]); // R2

  AST_NO_SPURIOUS_SET: assert property (@(posedge clk) disable iff (!rst_n)
    !done_vld |=> (flags_o & ~$past(flags_o)) == '0); // R2

  AST_UNPOWERED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_en |=> (flags_o & $past(flags_o)) == $past(flags_o)); // R3

  AST_SEQ_WIPE: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_en && seq_start_wr |=> flags_o == '0); // R8

  AST_FAST_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_en && fast_clr && res_rd && !seq_start_wr && !(done_vld && done_pos == res_idx)
    |=> !flags_o[$past(res_idx)]); // R7

  AST_UNSEEN_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    !fast_clr && res_rd && flags_o[res_idx] && !seen_q[res_idx] && !seq_start_wr
    |=> flags_o[$past(res_idx)]); // R6

  AST_MARK_SUBSET: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_q & ~flags_o) == '0); // R10

  AST_SEQ_DROPS_MARKS: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_en && seq_start_wr |=> seen_q == '0); // R11

  AST_NEW_SET_UNMARKED: assert property (@(posedge clk) disable iff (!rst_n)
    stat_rd && done_vld && !flags_o[done_pos] && !res_rd && !seq_start_wr
    |=> !seen_q[$past(done_pos)]); // R12
endmodule

bind cvt_done_flags cdf_chk #(.NUM_POS(NUM_POS), .IDX_W(IDX_W)) chk_i (
  .clk          (clk),
  .rst_n        (rst_sync_n),
  .done_vld     (done_vld),
  .done_pos     (done_pos),
  .pwr_en       (pwr_en),
  .fast_clr     (fast_clr),
  .seq_start_wr (seq_start_wr),
  .stat_rd      (stat_rd),
  .res_rd       (res_rd),
  .res_idx      (res_idx),
  .seen_q       (seen_q),
  .flags_o      (flags_o)
);

// File: tb/cvt_done_flags_tb_top.sv
module cvt_done_flags_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       done_vld = 1'b0;
  logic [2:0] done_pos = 3'd0;
  logic       pwr_en = 1'b0;
  logic       fast_clr = 1'b0;
  logic       seq_start_wr = 1'b0;
  logic       stat_rd = 1'b0;
  logic       res_rd = 1'b0;
  logic [2:0] res_idx = 3'd0;
  logic [7:0] flags_o;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  logic [7:0] exp_q[$];
  string      tag_q[$];

  // Bench reference state, built from the requirement text
  logic [7:0] m_flags = 8'h00;
  logic [7:0] m_seen  = 8'h00;

  always #2 clk = ~clk;

  cvt_done_flags dut_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .done_vld     (done_vld),
    .done_pos     (done_pos),
    .pwr_en       (pwr_en),
    .fast_clr     (fast_clr),
    .seq_start_wr (seq_start_wr),
    .stat_rd      (stat_rd),
    .res_rd       (res_rd),
    .res_idx      (res_idx),
    .flags_o      (flags_o)
  );

  task automatic check(input logic [7:0] act, input logic [7:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: flags actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  // Driver: one cycle of stimulus, expected result pushed to the scoreboard
  task automatic drive(input bit dv, input int dp, input bit st, input bit rr,
                       input int ri, input bit sq, input string tag);
    logic [7:0] set_v, hit_v, clr_v;
    @(negedge clk);
    done_vld     = dv;
    done_pos     = 3'(dp);
    stat_rd      = st;
    res_rd       = rr;
    res_idx      = 3'(ri);
    seq_start_wr = sq;
    set_v = dv ? (8'h01 << dp) : 8'h00;
    hit_v = rr ? (8'h01 << ri) : 8'h00;
    clr_v = pwr_en ? (fast_clr ? hit_v : (hit_v & m_seen)) : 8'h00;
    if (pwr_en && sq) begin
      m_flags = 8'h00;
      m_seen  = 8'h00;
    end else begin
      m_seen  = (m_seen | (st ? m_flags : 8'h00)) & ~clr_v;
      m_flags = (m_flags & ~clr_v) | set_v;
    end
    exp_q.push_back(m_flags);
    tag_q.push_back(tag);
  endtask

  task automatic idle(input string tag);
    drive(0, 0, 0, 0, 0, 0, tag);
  endtask

  // Monitor: compares one cycle after each driven edge
  always @(posedge clk) begin
    #1;
    if (exp_q.size() > 0) begin
      logic [7:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check(flags_o, e, t);
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(flags_o, 8'h00, "R1 during reset");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(flags_o, 8'h00, "R1 after release");
    pwr_en = 1'b1;

    // R2: sets at several slots
    drive(1, 3, 0, 0, 0, 0, "R2 set 3");
    drive(1, 0, 0, 0, 0, 0, "R2 set 0");
    drive(1, 7, 0, 0, 0, 0, "R2 set 7");
    idle("R2 hold");

    // R7: fast clear of one slot
    fast_clr = 1'b1;
    drive(0, 0, 0, 1, 3, 0, "R7 fast read 3");
    drive(0, 0, 0, 1, 5, 0, "R7 read of clear slot");

    // R3: unpowered, no clear
    pwr_en = 1'b0;
    drive(0, 0, 0, 1, 0, 0, "R3 read unpowered");
    drive(0, 0, 0, 0, 0, 1, "R3 seq start unpowered");
    drive(1, 1, 0, 0, 0, 0, "R3 set unpowered");
    pwr_en = 1'b1;

    // R4: sequence start clears all
    drive(0, 0, 0, 0, 0, 1, "R4 seq start");

    // R6 / R5: paired mode
    fast_clr = 1'b0;
    drive(1, 2, 0, 0, 0, 0, "R6 set 2");
    drive(0, 0, 0, 1, 2, 0, "R6 read without status");
    drive(0, 0, 1, 0, 0, 0, "R5 status read");
    drive(0, 0, 0, 1, 2, 0, "R5 result read clears");

    // R12: set in same cycle as status read is not marked
    drive(1, 5, 1, 0, 0, 0, "R12 set with status");
    drive(0, 0, 0, 1, 5, 0, "R12 read stays set");

    // R10: mark used up
    drive(1, 4, 0, 0, 0, 0, "R10 set 4");
    drive(0, 0, 1, 0, 0, 0, "R10 status read");
    drive(0, 0, 0, 1, 4, 0, "R10 first read clears");
    drive(1, 4, 0, 0, 0, 0, "R10 set 4 again");
    drive(0, 0, 0, 1, 4, 0, "R10 second read stays");

    // R11: sequence start drops marks
    drive(0, 0, 1, 0, 0, 0, "R11 status read");
    drive(0, 0, 0, 0, 0, 1, "R11 seq start");
    drive(1, 4, 0, 0, 0, 0, "R11 set 4");
    drive(0, 0, 0, 1, 4, 0, "R11 read stays");

    // R9: read clear loses to set, both modes
    drive(0, 0, 1, 0, 0, 0, "R9 status read");
    drive(1, 4, 0, 1, 4, 0, "R9 paired collide");
    fast_clr = 1'b1;
    drive(1, 6, 0, 0, 0, 0, "R9 set 6");
    drive(1, 6, 0, 1, 6, 0, "R9 fast collide");

    // R8: sequence start beats a set
    drive(1, 1, 0, 0, 0, 1, "R8 seq start with set");
    idle("R8 hold");

    wait (exp_q.size() == 0);
    @(negedge clk);
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule